// File: doc/BRIEF.md
# Four-Point Integer Forward Transform Row Stage

This block computes the one-dimensional forward transform of four signed residual samples using the standard video-coding integer basis, whose magnitudes are 64, 83 and 36. One core folds its inputs into sums and differences. The even outputs are then built from the sums and the odd outputs from the differences, so every product is a fixed shift-and-add and no general multiplier is needed. Each result is rounded, shifted right by a parameter and clamped back to a signed 16-bit word.

The top places several cores side by side. With the default of four lanes, this gives the complete row pass of a 4x4 block: 16 samples in and 16 coefficients out. A single output register, loaded under a clock enable, holds the coefficients until the next load. A flag marks the cycle after each load. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `dct4_row_stage`

## Requirements
- R1: Coefficient 0 of each lane equals the rounded, shifted, clamped value of 64*(x0+x1+x2+x3).
- R2: Coefficient 2 of each lane equals the rounded, shifted, clamped value of 64*(x0-x1-x2+x3); it is 0 when all four samples are equal.
- R3: Coefficient 1 of each lane equals the rounded, shifted, clamped value of 83*x0+36*x1-36*x2-83*x3; it is 0 when all four samples are equal.
- R4: Coefficient 3 of each lane equals the rounded, shifted, clamped value of 36*x0-83*x1+83*x2-36*x3; it is 0 when all four samples are equal.
- R5: Rounding adds 2^(SHIFT-1) to the exact sum and then shifts arithmetically right by SHIFT (default 1), so that 83 gives 42 and -83 gives -41.
- R6: A result outside -32768..32767 after the shift is clamped to the nearer limit.
- R7: Sample k of lane l is at bits [(4*l+k)*16 +: 16] of `samp_i`, and coefficient k of lane l is at the same position in `coef_o`. The lanes do not interact.
- R8: Coefficients are loaded at a rising clock edge where `en` is high and appear after that edge; while `en` is low, `coef_o` holds its value.
- R9: While reset is held low, `coef_o` is all zero and `out_vld` is 0; loads resume only two rising edges after the reset is released.
- R10: Outside reset, `out_vld` equals the value that `en` had at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Load enable for the output register |
| samp_i | input | LANES*4*DW (256) | Packed signed input samples, layout as in R7 |
| coef_o | output | LANES*4*DW (256) | Packed signed coefficients, layout as in R7 |
| out_vld | output | 1 | High in the cycle after a load |

## Verification
On every cycle, the assertions check three things: the register holds while the enable is low, the valid flag tracks the enable one edge later, and every lane's odd and alternating-even coefficients vanish whenever a flat input was loaded. The arithmetic itself can only be shown by the bench's scenarios. Its reference is a full matrix multiply, and its scenarios drive rounding at both signs, clamping at both rails, mixed data across all lanes, and reset release.

// File: rtl/dct4_pkg.sv
package dct4_pkg;
  // points per transform
  localparam int unsigned TAPS = 4;
  // headroom added above the sample width for the butterfly sums
  localparam int unsigned GUARD_BITS = 9;
endpackage

// File: rtl/dct4_rst_sync.sv
module dct4_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic meta_q, sync_q;
  logic meta_d, sync_d;

  always_comb begin
    meta_d = 1'b1;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q;
endmodule

// File: rtl/dct4_cmul.sv
module dct4_cmul #(
  parameter int unsigned W      = 25,
  parameter int          FACTOR = 64
) (
  input  logic signed [W-1:0] v_i,
  output logic signed [W-1:0] p_o
);
  generate
    if (FACTOR == 64) begin : g_x64
      assign p_o = v_i <<< 6;
    end else if (FACTOR == 83) begin : g_x83
      // 83 = 64 + 16 + 2 + 1
      assign p_o = (v_i <<< 6) + (v_i <<< 4) + (v_i <<< 1) + v_i;
    end else if (FACTOR == 36) begin : g_x36
      // 36 = 32 + 4
      assign p_o = (v_i <<< 5) + (v_i <<< 2);
    end else begin : g_generic
      assign p_o = v_i * W'(FACTOR);
    end
  endgenerate
endmodule

// File: rtl/dct4_round_sat.sv
module dct4_round_sat #(
  parameter int unsigned IW    = 25,
  parameter int unsigned OW    = 16,
  parameter int unsigned SHIFT = 1
) (
  input  logic signed [IW-1:0] acc_i,
  output logic signed [OW-1:0] q_o
);
  localparam int RND_I = (1 << SHIFT) >> 1;
  localparam logic signed [IW:0] RND    = (IW+1)'(RND_I);
  localparam logic signed [IW:0] HI_LIM = (IW+1)'((2 ** (OW-1)) - 1);
  localparam logic signed [IW:0] LO_LIM = (IW+1)'(-(2 ** (OW-1)));

  logic signed [IW:0] biased;
  logic signed [IW:0] shifted;

  always_comb begin
    biased  = $signed({acc_i[IW-1], acc_i}) + RND;
    shifted = biased >>> SHIFT;
    if (shifted > HI_LIM) begin
      q_o = HI_LIM[OW-1:0];
    end else if (shifted < LO_LIM) begin
      q_o = LO_LIM[OW-1:0];
    end else begin
      q_o = shifted[OW-1:0];
    end
  end
endmodule

// File: rtl/dct4_core.sv
module dct4_core
  import dct4_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned SHIFT = 1
) (
  input  logic [TAPS*DW-1:0] x_i,
  output logic [TAPS*DW-1:0] y_o
);
  localparam int unsigned IW = DW + GUARD_BITS;

  logic signed [IW-1:0] xe [TAPS];
  logic signed [IW-1:0] a0, a1, b0, b1, e0, e1;
  logic signed [IW-1:0] p64_e0, p64_e1, p83_b0, p83_b1, p36_b0, p36_b1;
  logic signed [IW-1:0] raw [TAPS];

  // sign-extend every sample into the guard width
  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_ext
      assign xe[k] = {{(IW-DW){x_i[k*DW+DW-1]}}, x_i[k*DW +: DW]};
    end
  endgenerate

  // folding stage: sums feed the even rows, differences the odd rows
  always_comb begin
    a0 = xe[0] + xe[3];
    a1 = xe[1] + xe[2];
    b0 = xe[0] - xe[3];
    b1 = xe[1] - xe[2];
    e0 = a0 + a1;
    e1 = a0 - a1;
  end

  dct4_cmul #(.W(IW), .FACTOR(64)) u_m64_e0 (.v_i(e0), .p_o(p64_e0));
  dct4_cmul #(.W(IW), .FACTOR(64)) u_m64_e1 (.v_i(e1), .p_o(p64_e1));
  dct4_cmul #(.W(IW), .FACTOR(83)) u_m83_b0 (.v_i(b0), .p_o(p83_b0));
  dct4_cmul #(.W(IW), .FACTOR(83)) u_m83_b1 (.v_i(b1), .p_o(p83_b1));
  dct4_cmul #(.W(IW), .FACTOR(36)) u_m36_b0 (.v_i(b0), .p_o(p36_b0));
  dct4_cmul #(.W(IW), .FACTOR(36)) u_m36_b1 (.v_i(b1), .p_o(p36_b1));

  always_comb begin
    raw[0] = p64_e0;
    raw[1] = p83_b0 + p36_b1;
    raw[2] = p64_e1;
    raw[3] = p36_b0 - p83_b1;
  end

  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_out
      dct4_round_sat #(.IW(IW), .OW(DW), .SHIFT(SHIFT)) u_rs (
        .acc_i (raw[k]),
        .q_o   (y_o[k*DW +: DW])
      );
    end
  endgenerate
endmodule

// File: rtl/dct4_row_stage.sv
module dct4_row_stage
  import dct4_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 4,
  parameter int unsigned SHIFT = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [LANES*TAPS*DW-1:0]    samp_i,
  output logic [LANES*TAPS*DW-1:0]    coef_o,
  output logic                        out_vld
);
  localparam int unsigned LW = TAPS * DW;
  localparam int unsigned VW = LANES * LW;

  logic          rst_n_s;
  logic [VW-1:0] comb_w;
  logic [VW-1:0] coef_d, coef_q;
  logic          vld_d, vld_q;

  dct4_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      dct4_core #(.DW(DW), .SHIFT(SHIFT)) u_core (
        .x_i (samp_i[l*LW +: LW]),
        .y_o (comb_w[l*LW +: LW])
      );
    end
  endgenerate

  // next-state
  always_comb begin
    coef_d = coef_q;
    if (en) begin
      coef_d = comb_w;
    end
    vld_d = en;
  end

  // register
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      coef_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      coef_q <= coef_d;
      vld_q  <= vld_d;
    end
  end

  assign coef_o  = coef_q;
  assign out_vld = vld_q;

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(rst_n_s) && !$past(en)) |-> $stable(coef_o));

  // R10
  vld_track_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> (out_vld == $past(en)));

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_chk
      // R3 R4
      flat_odd_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        ($past(rst_n_s) && $past(en) &&
         ($past(samp_i[l*LW +: DW]) == $past(samp_i[l*LW + DW +: DW])) &&
         ($past(samp_i[l*LW +: DW]) == $past(samp_i[l*LW + 2*DW +: DW])) &&
         ($past(samp_i[l*LW +: DW]) == $past(samp_i[l*LW + 3*DW +: DW])))
        |-> (coef_o[l*LW + DW +: DW] == '0 && coef_o[l*LW + 3*DW +: DW] == '0));
      // R2
      flat_even_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
        ($past(rst_n_s) && $past(en) &&
         ($past(samp_i[l*LW +: DW]) == $past(samp_i[l*LW + DW +: DW])) &&
         ($past(samp_i[l*LW +: DW]) == $past(samp_i[l*LW + 2*DW +: DW])) &&
         ($past(samp_i[l*LW +: DW]) == $past(samp_i[l*LW + 3*DW +: DW])))
        |-> (coef_o[l*LW + 2*DW +: DW] == '0));
    end
  endgenerate
endmodule

// File: tb/dct4_row_stage_test.sv
module dct4_row_stage_test;
  localparam int DW = 16;
  localparam int LANES = 4;
  localparam int SHIFT = 1;
  localparam int NV = LANES * 4;
  localparam int VW = NV * DW;
  localparam int BASIS [4][4] = '{'{64, 64, 64, 64}, '{83, 36, -36, -83},
                                  '{64, -64, -64, 64}, '{36, -83, 83, -36}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [VW-1:0] samp_i;
  logic [VW-1:0] coef_o;
  logic          out_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dct4_row_stage #(.DW(DW), .LANES(LANES), .SHIFT(SHIFT)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .samp_i(samp_i),
    .coef_o(coef_o), .out_vld(out_vld)
  );

  function automatic int clamp_round(int acc);
    int t;
    t = (acc + ((1 << SHIFT) >> 1)) >>> SHIFT;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  function automatic int smp(int idx);
    return int'($signed(samp_i[idx*DW +: DW]));
  endfunction

  function automatic int outv(int idx);
    return int'($signed(coef_o[idx*DW +: DW]));
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0: return "R1";
      1: return "R3";
      2: return "R2";
      default: return "R4";
    endcase
  endfunction

  // behavioural model: full matrix multiply behind a mirrored reset release
  int exp_c [NV];
  bit exp_v;
  bit s1, s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; exp_v <= 1'b0;
      for (int i = 0; i < NV; i++) exp_c[i] <= 0;
    end else begin
      s1 <= 1'b1;
      s2 <= s1;
      if (s2) begin
        exp_v <= en;
        if (en) begin
          for (int l = 0; l < LANES; l++) begin
            for (int k = 0; k < 4; k++) begin
              int acc;
              acc = 0;
              for (int n = 0; n < 4; n++) acc += BASIS[k][n] * smp(l*4 + n);
              exp_c[l*4 + k] <= clamp_round(acc);
            end
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle compare, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int i = 0; i < NV; i++) chk({tag_of(i % 4), "/R7 model"}, outv(i), exp_c[i]);
      chk("R10 model", int'(out_vld), int'(exp_v));
    end
  end

  task automatic put(int lane, int k, int v);
    samp_i[(lane*4 + k)*DW +: DW] = DW'(v);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; samp_i = '1;
    repeat (3) @(negedge clk);
    // R9: reset contents
    for (int i = 0; i < NV; i++) chk("R9 reset coef", outv(i), 0);
    chk("R9 reset vld", int'(out_vld), 0);
    en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R9: first edge after release still holds reset, even with en high
    en = 1'b1;
    @(negedge clk);
    chk("R9 release delay", int'(out_vld), 0);
    en = 1'b0;
    repeat (2) @(negedge clk);
    cmp_on = 1'b1;

    // directed: rounding, clamping, lane isolation
    samp_i = '0;
    put(0, 0, 1);
    put(1, 0, -1);
    for (int k = 0; k < 4; k++) put(2, k, 32767);
    for (int k = 0; k < 4; k++) put(3, k, -32768);
    en = 1'b1;
    @(negedge clk);
    chk("R5 pos y0", outv(0), 32);
    chk("R5 pos y1", outv(1), 42);
    chk("R5 pos y3", outv(3), 18);
    chk("R5 neg y0", outv(4), -32);
    chk("R5 neg y1", outv(5), -41);
    chk("R5 neg y3", outv(7), -18);
    chk("R6 high rail", outv(8), 32767);
    chk("R6 low rail", outv(12), -32768);
    chk("R2 flat lane", outv(10), 0);
    chk("R7 lane0 unaffected y2", outv(2), 32);
    chk("R10 vld after load", int'(out_vld), 1);

    // R8: inputs change with enable low, output holds
    en = 1'b0;
    samp_i = '1;
    @(negedge clk);
    chk("R8 hold y0", outv(0), 32);
    chk("R8 hold rail", outv(12), -32768);
    chk("R10 vld low", int'(out_vld), 0);

    // odd-part clamp: 83*32767 - 83*(-32768) far above range
    put(0, 0, 32767); put(0, 1, 0); put(0, 2, 0); put(0, 3, -32768);
    put(0, 0, 32767);
    en = 1'b1;
    @(negedge clk);
    chk("R6 odd clamp y1", outv(1), 32767);
    chk("R6 odd clamp y3", outv(3), 32767);

    // mixed random traffic with random enables
    for (int c = 0; c < 3000; c++) begin
      int mode;
      mode = int'($urandom_range(0, 3));
      for (int i = 0; i < NV; i++) begin
        case (mode)
          0: samp_i[i*DW +: DW] = DW'($urandom);
          1: samp_i[i*DW +: DW] = DW'(int'($urandom_range(0, 15)) - 8);
          2: samp_i[i*DW +: DW] = ($urandom_range(0, 1) != 0) ? 16'h7FFF : 16'h8000;
          default: samp_i[i*DW +: DW] = DW'(int'($urandom_range(0, 511)) - 256);
        endcase
      end
      en = ($urandom_range(0, 3) != 0);
      @(negedge clk);
    end

    // R9: reset again mid-run
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < NV; i++) chk("R9 async clear", outv(i), 0);
    cmp_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b0;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    cmp_on = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule